// File: doc/BRIEF.md
# Polled SPI Word Receiver

This block is an SPI slave that receives data only. It runs in a fast system clock domain. The serial clock, the active-low select and the data input are treated as asynchronous. Each of them passes through a flip-flop synchronizer chain of configurable depth. After the chain, the block detects edges of the serial clock in the system domain and shifts in data on the rising edge, MSB first. This is clock polarity 1 with clock phase 1. Each low period of select carries exactly one word.

A completed word goes into a single holding register. There is no queue behind it. Software polls a two-entry register port:
- A status word carries a ready flag and an overrun flag.
- A data register returns the held word.

Reading the data register consumes the word and clears the ready flag. If a new word arrives before the old one was read, it replaces the old word and sets a sticky overrun flag. Software clears that flag by writing the status register. The serial output toward the master is held at 0.

Top module: `spi_word_receiver`

## Requirements
- R1: After reset, a read of the status register (offset 1) returns 0x00, a read of the data register (offset 0) returns 0x00, and `miso_o` is 0.
- R2: While select is low, the bit on `mosi_i` is captured on each rising edge of `sclk_i`. The first captured bit becomes bit 7 of the word.
- R3: If select goes high before 8 bits have been captured, the partial bits are dropped. The ready flag stays clear, and the next select period starts a fresh word.
- R4: When the 8th bit of a select period is captured, the word moves to the holding register and the ready flag (status bit 7) is set.
- R5: A read of offset 0 returns the held word and clears the ready flag. A read of offset 1 changes no flag.
- R6: A word that completes while the ready flag is set overwrites the held word and sets the overrun flag (status bit 3).
- R7: The overrun flag stays set across data reads until a write to offset 1. That write clears the overrun flag and leaves the ready flag unchanged.
- R8: Read data and `bus_rvalid` appear in the cycle after the one in which `bus_rd` is high.
- R9: `miso_o` is constant 0 at all times, including during transfers.
- R10: Words framed by separate select periods are received independently and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master, idle high |
| ss_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, held at 0 |
| bus_addr | input | ADDR_W | Register offset: 0 for data, 1 for status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WORD_W | Write data (the value is ignored) |
| bus_rdata | output | WORD_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |

## Verification
The assertions check the following on every cycle:
- A completed word sets the ready flag.
- A data read without a new word clears the ready flag.
- An overwrite sets the overrun flag.
- The overrun flag holds until a status write.
- The bit counter is idle while select is high.
- Every read strobe is answered one cycle later.

The directed scenarios are the only way to show end-to-end behaviour through the register port:
- the bit order of captured words;
- that a partial word is dropped;
- that the held value is the newest word after an overrun;
- that a status write leaves the ready flag alone.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_STAT = 1;
  localparam int RDY_BIT  = 7;
  localparam int OVR_BIT  = 3;
endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= RST_VAL;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic              sclk_d;
  logic              sclk_rise;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign shreg_nxt = {shreg[WORD_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      word_done <= 1'b0;
      word      <= '0;
    end else begin
      sclk_d    <= sclk_s;
      word_done <= 1'b0;
      if (ss_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= shreg_nxt;
        if (bit_cnt == CNT_W'(WORD_W-1)) begin
          bit_cnt   <= '0;
          word      <= shreg_nxt;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_regs.sv
module spi_rx_regs
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              rdy_q,
  output logic              ovr_q
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] status_w;
  logic              rd_data_hit;
  logic              wr_stat_hit;

  assign rd_data_hit = bus_rd && (bus_addr == ADDR_W'(REG_DATA));
  assign wr_stat_hit = bus_wr && (bus_addr == ADDR_W'(REG_STAT));

  always_comb begin
    status_w          = '0;
    status_w[RDY_BIT] = rdy_q;
    status_w[OVR_BIT] = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (word_done) hold_q <= word;

      if (word_done)        rdy_q <= 1'b1;
      else if (rd_data_hit) rdy_q <= 1'b0;

      if (word_done && rdy_q && !rd_data_hit) ovr_q <= 1'b1;
      else if (wr_stat_hit)                   ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (bus_addr == ADDR_W'(REG_DATA))      bus_rdata <= hold_q;
        else if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata <= status_w;
        else                                    bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_word_receiver.sv
module spi_word_receiver #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              ss_n_s;
  logic              mosi_s;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rdy_q;
  logic              ovr_q;
  logic              unused_wdata;

  assign miso_o       = 1'b0;
  assign unused_wdata = ^bus_wdata;

  spi_sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({sclk_i, ss_n_i, mosi_i}), .q(pins_s)
  );
  assign {sclk_s, ss_n_s, mosi_s} = pins_s;

  spi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
    .word_done(word_done), .word(word), .bit_cnt(bit_cnt)
  );

  spi_rx_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .word_done(word_done), .word(word),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rdy_q(rdy_q), .ovr_q(ovr_q)
  );
endmodule

// File: rtl/spi_rx_checker.sv
module spi_rx_checker #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_rvalid,
  input logic              word_done,
  input logic              rdy_q,
  input logic              ovr_q,
  input logic              ss_n_s,
  input logic [CNT_W-1:0]  bit_cnt
);
  logic rd_data;
  logic wr_stat;
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(0));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(1));

  a_r4_ready_on_word: assert property (@(posedge clk) disable iff (rst)
    word_done |=> rdy_q);

  a_r5_ready_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !word_done) |=> !rdy_q);

  a_r6_overrun_on_overwrite: assert property (@(posedge clk) disable iff (rst)
    (word_done && rdy_q && !rd_data) |=> ovr_q);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !wr_stat) |=> ovr_q);

  a_r3_count_idle: assert property (@(posedge clk) disable iff (rst)
    ss_n_s |=> (bit_cnt == '0));

  a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

bind spi_word_receiver spi_rx_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rvalid(bus_rvalid), .word_done(word_done), .rdy_q(rdy_q), .ovr_q(ovr_q),
  .ss_n_s(ss_n_s), .bit_cnt(bit_cnt)
);

// File: tb/spi_word_receiver_tb_top.sv
module spi_word_receiver_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       sclk_i, ss_n_i, mosi_i;
  logic       miso_o;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int tests = 0;
  int fails = 0;
  logic [7:0] rd_val;

  always #4 clk = ~clk;

  spi_word_receiver dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic logic [7:0] stat(input logic rdy, input logic ovr);
    stat = {rdy, 3'b000, ovr, 3'b000};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R8 rvalid", {7'd0, bus_rvalid}, 8'h01);
    v = bus_rdata;
  endtask

  task automatic reg_write_status();
    @(negedge clk);
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] w, input int nbits);
    @(negedge clk);
    ss_n_i = 1'b0;
    wait_clks(6);
    for (int b = 0; b < nbits; b++) begin
      sclk_i = 1'b0; mosi_i = w[7-b];
      check("R9 miso", {7'd0, miso_o}, 8'h00);
      wait_clks(6);
      sclk_i = 1'b1;
      wait_clks(6);
    end
    wait_clks(4);
    ss_n_i = 1'b1;
    wait_clks(8);
  endtask

  task automatic t_reset();
    reg_read(2'd1, rd_val); check("R1 status", rd_val, 8'h00);
    reg_read(2'd0, rd_val); check("R1 data", rd_val, 8'h00);
    check("R1 miso", {7'd0, miso_o}, 8'h00);
  endtask

  task automatic t_single();
    send_bits(8'hA5, 8);
    reg_read(2'd1, rd_val); check("R4 ready set", rd_val, stat(1, 0));
    reg_read(2'd0, rd_val); check("R2 msb first A5", rd_val, 8'hA5);
    reg_read(2'd1, rd_val); check("R5 ready cleared", rd_val, stat(0, 0));
  endtask

  task automatic t_status_no_clear();
    send_bits(8'h3C, 8);
    reg_read(2'd1, rd_val); check("R5 status read 1", rd_val, stat(1, 0));
    reg_read(2'd1, rd_val); check("R5 status read 2", rd_val, stat(1, 0));
    reg_read(2'd0, rd_val); check("R2 data 3C", rd_val, 8'h3C);
  endtask

  task automatic t_partial();
    send_bits(8'hFF, 5);
    reg_read(2'd1, rd_val); check("R3 partial no ready", rd_val, stat(0, 0));
    send_bits(8'h81, 8);
    reg_read(2'd0, rd_val); check("R3 fresh word 81", rd_val, 8'h81);
  endtask

  task automatic t_overrun();
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    reg_read(2'd1, rd_val); check("R6 overrun flag", rd_val, stat(1, 1));
    reg_read(2'd0, rd_val); check("R6 newest word", rd_val, 8'h22);
    reg_read(2'd1, rd_val); check("R7 sticky after read", rd_val, stat(0, 1));
    send_bits(8'h33, 8);
    reg_read(2'd1, rd_val); check("R7 sticky with ready", rd_val, stat(1, 1));
    reg_write_status();
    reg_read(2'd1, rd_val); check("R7 write clears overrun", rd_val, stat(1, 0));
    reg_read(2'd0, rd_val); check("R7 data 33", rd_val, 8'h33);
  endtask

  task automatic t_sequence();
    logic [7:0] seq [3] = '{8'h5A, 8'hC3, 8'h0F};
    for (int k = 0; k < 3; k++) begin
      send_bits(seq[k], 8);
      reg_read(2'd0, rd_val); check("R10 word in order", rd_val, seq[k]);
    end
    reg_read(2'd1, rd_val); check("R10 no overrun", rd_val, stat(0, 0));
  endtask

  initial begin
    #1600000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; sclk_i = 1'b1; ss_n_i = 1'b1; mosi_i = 1'b0;
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(2);
    t_reset();
    t_single();
    t_status_no_clear();
    t_partial();
    t_overrun();
    t_sequence();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule